// File: doc/BRIEF.md
# Random TLB Refill Way Selector

When an address translation misses, this block chooses which of four TLB ways will receive the new entry and records the details of the miss so that a software refill handler can read them. The way is drawn from a 16-bit shift register with linear feedback. The register moves one step on every real miss and holds still at all other times.

On each real miss two 32-bit registers are loaded. The way-select register holds the chosen way and the entry index within that way. The cause register holds the virtual page number, the access type and the process ID. The index is the low four bits of the virtual page number. A lookup flagged as debug is a side-effect-free probe. It moves no state and overwrites no register.

The block has no state machine. Its only sequential state is the shift register and the two record registers. Each of these is either loaded or held in every cycle.

Top module: `refill_way_picker`

## Requirements
- R1: After reset the shift register reads 0xCCCC, and both the way-select and cause registers read zero.
- R2: On a miss with the debug flag low, the shift register shifts right by one bit. Its new bit 15 is the XOR of all bits of (old value AND 0x8805).
- R3: In a cycle with no miss, the shift register keeps its value.
- R4: A miss with the debug flag high leaves the shift register, the way-select register and the cause register unchanged.
- R5: The way output always equals bits 1:0 of the current shift register. The way stored on a miss is the value before that miss advances the register.
- R6: On a real miss, the way-select register is loaded as follows:
  - bits 3:0 take the virtual page bits 3:0;
  - bits 5:4 take the way;
  - bits 31:6 are zero.
  The index output always equals the virtual page bits 3:0.
- R7: On a real miss, the cause register is loaded as follows:
  - bits 31:13 take the 19-bit virtual page;
  - bits 9:8 take the access code (0 read, 1 write, 2 execute);
  - bits 7:0 take the 8-bit PID;
  - bits 12:10 are zero.
- R8: An access input of 3 is recorded as code 0 (read), so bits 9:8 of the cause register never hold 3.
- R9: Without a real miss, both record registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Synchronous reset, active low |
| miss_i | input | 1 | Translation miss strobe, one cycle per miss |
| debug_i | input | 1 | Marks the lookup as a debug probe |
| access_i | input | 2 | Access type: 0 read, 1 write, 2 execute |
| vpn_i | input | 19 | Virtual page number of the missing access |
| pid_i | input | 8 | Process ID of the missing access |
| refill_set_o | output | 2 | Way chosen for the refill |
| refill_idx_o | output | 4 | Entry index within the way |
| lfsr_o | output | 16 | Current shift register value |
| tlb_sel_o | output | 32 | Way-select register |
| cause_o | output | 32 | Cause register |

## Verification
Two functions can fall in the same clock edge: the sampling of the way into the way-select register and the advance of the shift register. R5 requires the stored way to be the value from before the step. To provoke this, the bench issues back-to-back real misses, with debug probes and idle cycles mixed in. A behavioural reference model is compared against every output on every clock. The stored way is judged against the model's value from before its own step.

// File: rtl/refill_pkg.sv
package refill_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2
    } access_e;

    // Raw code 3 has no meaning and falls back to a read.
    function automatic access_e norm_access(input logic [1:0] raw);
        unique case (raw)
            2'd1:    return ACC_WRITE;
            2'd2:    return ACC_EXEC;
            default: return ACC_READ;
        endcase
    endfunction

endpackage

// File: rtl/refill_lfsr.sv
module refill_lfsr #(
    parameter int              W    = 16,
    parameter logic [W-1:0]    SEED = 16'hCCCC,
    parameter logic [W-1:0]    TAPS = 16'h8805
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         adv_i,
    output logic [W-1:0] state_o
);

    logic [W-1:0] state_q;
    logic         feedback;

    always_comb feedback = ^(state_q & TAPS);

    always_ff @(posedge clk_i) begin
        if (!rst_ni)
            state_q <= SEED;
        else if (adv_i)
            state_q <= {feedback, state_q[W-1:1]};
    end

    assign state_o = state_q;

    assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !adv_i |=> $stable(state_q));

    assert_shift_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        adv_i |=> state_q[W-2:0] == $past(state_q[W-1:1]));

    assert_nonzero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_q != '0);

endmodule

// File: rtl/miss_recorder.sv
module miss_recorder
    import refill_pkg::*;
#(
    parameter int VPN_W   = 19,
    parameter int PID_W   = 8,
    parameter int IDX_W   = 4,
    parameter int SET_W   = 2,
    parameter int REG_W   = 32,
    parameter int VPN_LSB = 13,
    parameter int ACC_LSB = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             rec_i,
    input  logic [SET_W-1:0] set_i,
    input  logic [VPN_W-1:0] vpn_i,
    input  logic [PID_W-1:0] pid_i,
    input  logic [1:0]       acc_i,
    output logic [REG_W-1:0] sel_o,
    output logic [REG_W-1:0] cause_o
);

    localparam int SET_LSB = IDX_W;

    logic [REG_W-1:0] sel_q, cause_q, sel_d, cause_d;
    access_e          acc_code;

    always_comb begin
        acc_code = norm_access(acc_i);
        sel_d = '0;
        sel_d[IDX_W-1:0] = vpn_i[IDX_W-1:0];
        sel_d[SET_LSB +: SET_W] = set_i;
        cause_d = '0;
        cause_d[PID_W-1:0] = pid_i;
        cause_d[ACC_LSB +: 2] = acc_code;
        cause_d[VPN_LSB +: VPN_W] = vpn_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sel_q   <= '0;
            cause_q <= '0;
        end else if (rec_i) begin
            sel_q   <= sel_d;
            cause_q <= cause_d;
        end
    end

    assign sel_o   = sel_q;
    assign cause_o = cause_q;

    assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rec_i |=> ($stable(sel_q) && $stable(cause_q)));

    assert_code_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cause_q[ACC_LSB +: 2] != 2'd3);

    assert_clean_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel_q[REG_W-1:SET_LSB+SET_W] == '0);

endmodule

// File: rtl/refill_way_picker.sv
module refill_way_picker #(
    parameter int           LFSR_W  = 16,
    parameter logic [15:0]  SEED    = 16'hCCCC,
    parameter logic [15:0]  TAPS    = 16'h8805,
    parameter int           VPN_W   = 19,
    parameter int           PID_W   = 8,
    parameter int           IDX_W   = 4,
    parameter int           SET_W   = 2,
    parameter int           REG_W   = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              miss_i,
    input  logic              debug_i,
    input  logic [1:0]        access_i,
    input  logic [VPN_W-1:0]  vpn_i,
    input  logic [PID_W-1:0]  pid_i,
    output logic [SET_W-1:0]  refill_set_o,
    output logic [IDX_W-1:0]  refill_idx_o,
    output logic [LFSR_W-1:0] lfsr_o,
    output logic [REG_W-1:0]  tlb_sel_o,
    output logic [REG_W-1:0]  cause_o
);

    localparam int VPN_LSB = REG_W - VPN_W;
    localparam int ACC_LSB = PID_W;

    logic              real_miss;
    logic [LFSR_W-1:0] lfsr_state;
    logic [SET_W-1:0]  way_now;

    assign real_miss = miss_i & ~debug_i;

    refill_lfsr #(
        .W   (LFSR_W),
        .SEED(SEED[LFSR_W-1:0]),
        .TAPS(TAPS[LFSR_W-1:0])
    ) u_lfsr (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .adv_i  (real_miss),
        .state_o(lfsr_state)
    );

    assign way_now = lfsr_state[SET_W-1:0];

    miss_recorder #(
        .VPN_W  (VPN_W),
        .PID_W  (PID_W),
        .IDX_W  (IDX_W),
        .SET_W  (SET_W),
        .REG_W  (REG_W),
        .VPN_LSB(VPN_LSB),
        .ACC_LSB(ACC_LSB)
    ) u_rec (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .rec_i  (real_miss),
        .set_i  (way_now),
        .vpn_i  (vpn_i),
        .pid_i  (pid_i),
        .acc_i  (access_i),
        .sel_o  (tlb_sel_o),
        .cause_o(cause_o)
    );

    assign refill_set_o = way_now;
    assign refill_idx_o = vpn_i[IDX_W-1:0];
    assign lfsr_o       = lfsr_state;

    assert_debug_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (miss_i && debug_i) |=> ($stable(lfsr_o) && $stable(tlb_sel_o) && $stable(cause_o)));

    assert_setsrc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        real_miss |=> tlb_sel_o[IDX_W +: SET_W] == $past(lfsr_o[SET_W-1:0]));

endmodule

// File: tb/refill_way_picker_test.sv
`timescale 1ns/1ps
module refill_way_picker_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        miss = 1'b0;
    logic        dbg = 1'b0;
    logic [1:0]  acc = 2'd0;
    logic [18:0] vpn = '0;
    logic [7:0]  pid = '0;
    logic [1:0]  set_o;
    logic [3:0]  idx_o;
    logic [15:0] lfsr_o;
    logic [31:0] sel_o, cause_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int m_lfsr;
    logic [31:0] m_sel, m_cause;

    always #2 clk = ~clk;

    refill_way_picker uut (
        .clk_i(clk), .rst_ni(rst_n), .miss_i(miss), .debug_i(dbg),
        .access_i(acc), .vpn_i(vpn), .pid_i(pid),
        .refill_set_o(set_o), .refill_idx_o(idx_o), .lfsr_o(lfsr_o),
        .tlb_sel_o(sel_o), .cause_o(cause_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int lfsr_step(input int s);
        int fb = 0;
        for (int i = 0; i < 16; i++)
            fb ^= ((s >> i) & 1) & ((16'h8805 >> i) & 1);
        return ((s >> 1) | (fb << 15)) & 16'hFFFF;
    endfunction

    task automatic compare_all(input string lt, input string rt, input string ct);
        check(lt, {16'h0, lfsr_o}, m_lfsr[31:0]);
        check("R5", {30'h0, set_o}, m_lfsr[31:0] & 32'h3);
        check("R6", {28'h0, idx_o}, {28'h0, vpn[3:0]});
        check(rt, sel_o, m_sel);
        check(ct, cause_o, m_cause);
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        string lt, rt, ct;
        m_lfsr = 16'hCCCC; m_sel = '0; m_cause = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values
        compare_all("R1", "R1", "R1");
        lt = "R3"; rt = "R9"; ct = "R9";
        for (int n = 0; n < 400; n++) begin
            int r;
            r = $urandom_range(0, 9);
            miss = (r < 7);
            dbg  = (r == 5 || r == 6);
            acc  = 2'($urandom_range(0, 3));
            vpn  = 19'($urandom);
            pid  = 8'($urandom);
            if (n < 8) begin miss = 1'b1; dbg = 1'b0; end // back-to-back real misses
            if (miss && !dbg) begin
                int code;
                code = (acc == 2'd3) ? 0 : int'(acc);
                m_sel   = {26'h0, 2'(m_lfsr & 3), vpn[3:0]};
                m_cause = {vpn, 3'b000, 2'(code), pid};
                m_lfsr  = lfsr_step(m_lfsr);
                lt = "R2"; rt = "R6";
                ct = (acc == 2'd3) ? "R8" : "R7";
            end else if (miss) begin
                lt = "R4"; rt = "R4"; ct = "R4";
            end else begin
                lt = "R3"; rt = "R9"; ct = "R9";
            end
            @(negedge clk);
            compare_all(lt, rt, ct);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule